// File: doc/BRIEF.md
# MSI interrupt request handler

This block sits between a set of application interrupt sources and the message-signalled interrupt port of a PCIe transaction layer. Each source raises a one-cycle event. The event is recorded as a pending bit. When software has enabled message interrupts, the handler selects one pending source and raises a request toward the link side. The request carries a 5-bit message number and a 3-bit traffic class, and it stays raised until the link side acknowledges it.

Software may grant fewer message vectors than there are sources. The handler reads the granted count from the control word and reduces each source index to that count before driving it as the message number. The ordering between the status line and the acknowledge is fixed, so that the link side never sees a second interrupt that was not raised.

The controller has three states:
- **ST_IDLE**: waits for enable and a pending source.
- **ST_ASK**: holds the request and the status line.
- **ST_DRAIN**: waits for the acknowledge to drop.

The transitions are:
- **IDLE→ASK** (grant): the enable bit is set and at least one source is pending.
- **ASK→DRAIN** (take): the acknowledge is seen.
- **DRAIN→IDLE** (release): the acknowledge is low.

Top module: `msi_irq_handler`

## Requirements
- R1: Each one-cycle event on `src_evt[i]` sets a pending bit for source i, and each event that arrives while that source is not already pending leads to exactly one request.
- R2: `msi_req` stays high until `link_ack` is sampled high, and `msi_num` and `msi_tc` do not change while `msi_req` is high, even if the control word or `cfg_tc` changes.
- R3: `msi_tc` equals the value of `cfg_tc` in the cycle the request was granted.
- R4: The granted vector count is 2^MME. MME is `msi_ctl[6:4]`, and values 6 and 7 are treated as 32 vectors. `msi_num` is the source index modulo that count, which keeps only its low bits.
- R5: The enable bit is `msi_ctl[0]`. While it is clear, no request is issued and events stay pending. Once it is set, they are served.
- R6: When several sources are pending, the lowest index is served first.
- R7: A pending bit clears only on the acknowledge of its own request. An event that coincides with that acknowledge keeps the source pending.
- R8: `irq_sts` is high while the request is high and drops in the cycle after `link_ack` is sampled high. It is therefore never high in a cycle where `link_ack` falls.
- R9: No new request is raised while `link_ack` is still high after an acknowledge.
- R10: After reset, `msi_req` and `irq_sts` are low and no source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NUM_SRC | One-cycle interrupt events, one bit per source |
| msi_ctl | input | 16 | Control word: bit 0 is enable, bits [6:4] are the granted vector count exponent |
| cfg_tc | input | 3 | Traffic class to attach to the next request |
| link_ack | input | 1 | Acknowledge level from the link side |
| msi_req | output | 1 | Request strobe, held until acknowledged |
| msi_num | output | 5 | Message number, folded to the granted count |
| msi_tc | output | 3 | Traffic class of the current request |
| irq_sts | output | 1 | Interrupt status accompanying the request |

## Verification
The bench builds the block with the default NUM_SRC of 32. With 32 sources, index 31 and index 22 exercise every masking width from a single vector (MME of 0) up to the full 32 vectors, including the reserved codes. Simultaneous events on scattered indices bring the lowest-first ordering within reach. The link model in the bench holds the acknowledge high for several cycles. This exposes the status ordering and checks that no request is raised during the acknowledge tail.

// File: rtl/msi_pkg.sv
package msi_pkg;
    localparam int MSG_W = 5;
    localparam int TC_W  = 3;
    localparam int CTL_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ASK   = 2'd1,
        ST_DRAIN = 2'd2
    } msi_st_e;

    // Mask that keeps the low bits of an index for 2^mme granted vectors.
    function automatic logic [MSG_W-1:0] vec_mask(input logic [2:0] mme);
        logic [MSG_W-1:0] m;
        case (mme)
            3'd0:    m = 5'h00;
            3'd1:    m = 5'h01;
            3'd2:    m = 5'h03;
            3'd3:    m = 5'h07;
            3'd4:    m = 5'h0F;
            default: m = 5'h1F;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/msi_pend.sv
module msi_pend #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_oh,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_oh) | set_vec;
    end

    assign pend = pend_q;

    // R7
    pend_clear_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_q) & ~pend_q & ~$past(clr_oh)) == '0));
endmodule

// File: rtl/msi_pick.sv
module msi_pick #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req_vec,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    logic [NUM_SRC-1:0] below;
    logic [NUM_SRC-1:0] gnt;

    assign below[0] = 1'b0;
    assign gnt[0]   = req_vec[0];
    for (genvar i = 1; i < NUM_SRC; i++) begin : g_chain
        assign below[i] = below[i-1] | req_vec[i-1];
        assign gnt[i]   = req_vec[i] & ~below[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (gnt[i]) idx = idx | IDX_W'(i);
        end
    end

    assign any = |req_vec;

    // R6
    pick_onehot_chk: assert final ($onehot0(gnt));
endmodule

// File: rtl/msi_irq_handler.sv
module msi_irq_handler
    import msi_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [15:0]        msi_ctl,
    input  logic [2:0]         cfg_tc,
    input  logic               link_ack,
    output logic               msi_req,
    output logic [4:0]         msi_num,
    output logic [2:0]         msi_tc,
    output logic               irq_sts
);
    msi_st_e            st_q, st_d;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr_oh;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    logic [IDX_W-1:0]   sel_q;
    logic [MSG_W-1:0]   num_q;
    logic [TC_W-1:0]    tc_q;
    logic               grant, take;

    msi_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(src_evt),
        .clr_oh (clr_oh),
        .pend   (pend)
    );

    msi_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req_vec(pend),
        .any    (pick_any),
        .idx    (pick_idx)
    );

    assign grant  = (st_q == ST_IDLE) && msi_ctl[0] && pick_any;
    assign take   = (st_q == ST_ASK) && link_ack;
    assign clr_oh = take ? ({{(NUM_SRC-1){1'b0}}, 1'b1} << sel_q) : '0;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (grant)     st_d = ST_ASK;
            ST_ASK:   if (link_ack)  st_d = ST_DRAIN;
            ST_DRAIN: if (!link_ack) st_d = ST_IDLE;
            default:                 st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            num_q <= '0;
            tc_q  <= '0;
        end else if (grant) begin
            sel_q <= pick_idx;
            num_q <= MSG_W'(pick_idx) & vec_mask(msi_ctl[6:4]);
            tc_q  <= cfg_tc;
        end
    end

    always_comb begin
        msi_req = (st_q == ST_ASK);
        irq_sts = (st_q == ST_ASK);
        msi_num = num_q;
        msi_tc  = tc_q;
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_req && !link_ack) |=> msi_req);
    // R2
    num_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(msi_req) && msi_req) |-> ($stable(msi_num) && $stable(msi_tc)));
    // R8
    sts_before_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_ack) |-> !irq_sts);
    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_req) |-> $past(msi_ctl[0]));
    // R9
    no_req_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_req) |-> !$past(link_ack));
endmodule

// File: tb/msi_irq_handler_bench.sv
module msi_irq_handler_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_evt = '0;
    logic [15:0]     msi_ctl = '0;
    logic [2:0]      cfg_tc = '0;
    logic            link_ack = 1'b0;
    logic            msi_req;
    logic [4:0]      msi_num;
    logic [2:0]      msi_tc;
    logic            irq_sts;

    int checks = 0;
    int failures = 0;
    int ack_dly = 1;
    bit done = 0;

    typedef struct packed {
        logic [4:0] num;
        logic [2:0] tc;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_irq_handler #(.NUM_SRC(NSRC)) u_msi_irq_handler (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .msi_ctl(msi_ctl),
        .cfg_tc(cfg_tc), .link_ack(link_ack), .msi_req(msi_req),
        .msi_num(msi_num), .msi_tc(msi_tc), .irq_sts(irq_sts)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] fold(input int idx, input int mme);
        int cnt;
        cnt = (mme > 5) ? 32 : (1 << mme);
        return 5'(idx % cnt);
    endfunction

    task automatic set_ctl(input bit en, input int mme);
        msi_ctl = {9'b0, 3'(mme), 3'b0, en};
    endtask

    // Driver: record expected requests (lowest index first), then pulse events.
    task automatic fire(input logic [NSRC-1:0] v);
        for (int i = 0; i < NSRC; i++) begin
            if (v[i]) exp_q.push_back('{num: fold(i, int'(msi_ctl[6:4])), tc: cfg_tc});
        end
        src_evt = v;
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while ((exp_q.size() != 0 || msi_req || link_ack) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 2000, "R1 queue drained", exp_q.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    // Monitor and link model
    initial begin
        exp_t e;
        logic [4:0] n0;
        logic [2:0] t0;
        forever begin
            @(negedge clk);
            if (msi_req && rst_n) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R1 unexpected request", int'(msi_num), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(msi_num == e.num, "R4/R6 message number", int'(msi_num), int'(e.num));
                    chk(msi_tc == e.tc, "R3 traffic class", int'(msi_tc), int'(e.tc));
                end
                chk(irq_sts == 1'b1, "R8 status with request", int'(irq_sts), 1);
                n0 = msi_num;
                t0 = msi_tc;
                for (int k = 0; k < ack_dly; k++) begin
                    @(negedge clk);
                    chk(msi_req && msi_num == n0 && msi_tc == t0, "R2 held and stable",
                        int'(msi_num), int'(n0));
                end
                link_ack = 1'b1;
                @(negedge clk);
                chk(!msi_req && !irq_sts, "R8 status drops after ack", int'(irq_sts), 0);
                repeat (2) begin
                    @(negedge clk);
                    chk(!msi_req, "R9 no request during ack", int'(msi_req), 0);
                end
                link_ack = 1'b0;
                @(negedge clk);
                chk(!irq_sts, "R8 status low at ack drop", int'(irq_sts), 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk(!msi_req && !irq_sts, "R10 reset state", int'(msi_req), 0);

        // R5: disabled, event stays pending
        set_ctl(0, 5);
        cfg_tc = 3'd2;
        fire(32'h0000_0010);
        repeat (10) begin
            @(negedge clk);
            chk(!msi_req, "R5 no request while disabled", int'(msi_req), 0);
        end
        set_ctl(1, 5);
        drain();

        // R4: masking for each MME value, sources 31 and 22
        for (int m = 0; m < 8; m++) begin
            set_ctl(1, m);
            cfg_tc = 3'(m);
            fire(32'h8000_0000);
            drain();
            fire(32'h0040_0000);
            drain();
        end

        // R6 / R7: simultaneous sources, lowest first, others stay pending
        set_ctl(1, 5);
        cfg_tc = 3'd5;
        ack_dly = 3;
        fire(32'h0000_020A);
        drain();

        // R2: control and tc change while request is pending
        set_ctl(1, 5);
        cfg_tc = 3'd6;
        ack_dly = 4;
        fire(32'h0000_0080);
        @(negedge clk);
        @(negedge clk);
        set_ctl(1, 0);
        cfg_tc = 3'd1;
        drain();

        // R1: event repeated after service gives another request
        set_ctl(1, 4);
        ack_dly = 1;
        fire(32'h0002_0000);
        drain();
        fire(32'h0002_0000);
        drain();

        chk(exp_q.size() == 0, "R1 no missing request", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule